// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Unpacker

This block sits between the read side of a 36-bit long-word FIFO and a port that may be 36, 18 or 9 bits wide. It takes the long word at the head of the FIFO and hands it out as one 36-bit transfer, as two 18-bit words or as four 9-bit bytes. The bytes or words go out either most significant first (big endian) or least significant first (little endian).

The width and the lane order are taken from three configuration pins while master reset is held low, and they stay fixed until the next master reset. Each read strobe that finds data at the FIFO head loads the selected lane into the output register and moves a lane index forward. The FIFO is popped only on the read that delivers the last lane of the current long word. A partial reset restarts the lane sequence at the first lane of the head word and keeps the latched width and order.

Top module: `bm_unpacker`

## Requirements
- R1: While `mrst_n` is low, `cfg_narrow`=0 selects the 36-bit mode, `cfg_narrow`=1 with `cfg_byte`=1 selects the 9-bit mode, and `cfg_narrow`=1 with `cfg_byte`=0 selects the 18-bit mode, so one long word takes 1, 4 or 2 reads.
- R2: With `cfg_big`=1 at master reset, lane k of an n-lane word outputs bits [(n-1-k)*W +: W] of the head word (W = 36/n), so the most significant slice is delivered first.
- R3: With `cfg_big`=0 at master reset, lane k outputs bits [k*W +: W] of the head word, so the least significant slice is delivered first.
- R4: A master reset clears `rd_data` to all zeros and returns the lane index to the first lane.
- R5: A partial reset (`prst_n` low) clears `rd_data` to zero and restarts at the first lane of the head word, while the latched width and order are kept.
- R6: `fifo_pop` is high only in a cycle where `rd_en` and `fifo_valid` are both high and the last lane is being read. In the 36-bit mode every such read pops.
- R7: A read strobe while `fifo_valid` is low has no effect: `rd_data` holds, no pop is issued and the lane index does not move.
- R8: In the narrow modes the bits of `rd_data` above the lane width are zero.
- R9: Changes on `cfg_narrow`, `cfg_byte` and `cfg_big` after master reset has been released have no effect on width or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; latches the configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps the configuration |
| cfg_narrow | input | 1 | Bus-match select, sampled at master reset (1 = narrow bus) |
| cfg_byte | input | 1 | Size select for the narrow bus, sampled at master reset (1 = 9 bits, 0 = 18 bits) |
| cfg_big | input | 1 | Lane order, sampled at master reset (1 = big endian) |
| fifo_valid | input | 1 | The FIFO head holds a long word |
| fifo_data | input | 36 | Long word at the FIFO head |
| fifo_pop | output | 1 | Removes the head long word at this clock edge |
| rd_en | input | 1 | Read strobe on the narrow port |
| rd_data | output | 36 | Output register, zero-extended lane value |

## Verification
A lane index that is off by one shows at the ports on the next read. The wrong slice of the head word appears in `rd_data`, and `fifo_pop` comes one read early or late, so the following long word starts on a shifted lane. A wrongly latched mode or order is visible on the first read after master reset, either in the slice chosen or in nonzero upper bits. The bench sweeps all six width and order combinations across several long words and compares every lane and every pop against slices it computes. It also confirms that reads on an empty FIFO, pin changes after reset and a partial reset taken mid-word leave exactly the expected state behind.

// File: rtl/bm_unpacker.sv
module bm_unpacker #(
  parameter int BYTE_W = 9
) (
  input  logic                  clk,
  input  logic                  mrst_n,
  input  logic                  prst_n,
  input  logic                  cfg_narrow,
  input  logic                  cfg_byte,
  input  logic                  cfg_big,
  input  logic                  fifo_valid,
  input  logic [4*BYTE_W-1:0]   fifo_data,
  output logic                  fifo_pop,
  input  logic                  rd_en,
  output logic [4*BYTE_W-1:0]   rd_data
);
  localparam int LONG_W = 4 * BYTE_W;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {M_LONG = 2'd0, M_WORD = 2'd1, M_BYTE = 2'd2} mode_t;

  mode_t       mode_q;
  logic        big_q;
  logic [1:0]  lane_q;
  logic        last;
  logic [1:0]  sel_b;
  logic        sel_w;
  logic [LONG_W-1:0] nxt;

  logic [BYTE_W-1:0] bytes [4];
  logic [WORD_W-1:0] words [2];

  for (genvar g = 0; g < 4; g++) begin : g_byte
    assign bytes[g] = fifo_data[g*BYTE_W +: BYTE_W];
  end
  for (genvar g = 0; g < 2; g++) begin : g_word
    assign words[g] = fifo_data[g*WORD_W +: WORD_W];
  end

  wire fire = rd_en & fifo_valid;

  always_comb begin
    case (mode_q)
      M_LONG:  last = 1'b1;
      M_WORD:  last = lane_q[0];
      default: last = &lane_q;
    endcase
  end

  assign fifo_pop = fire & last;
  assign sel_b    = big_q ? ~lane_q : lane_q;
  assign sel_w    = big_q ^ lane_q[0];

  always_comb begin
    case (mode_q)
      M_LONG:  nxt = fifo_data;
      M_WORD:  nxt = {{(LONG_W-WORD_W){1'b0}}, words[sel_w]};
      default: nxt = {{(LONG_W-BYTE_W){1'b0}}, bytes[sel_b]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q  <= !cfg_narrow ? M_LONG : (cfg_byte ? M_BYTE : M_WORD);
      big_q   <= cfg_big;
      lane_q  <= 2'd0;
      rd_data <= '0;
    end else if (!prst_n) begin
      lane_q  <= 2'd0;
      rd_data <= '0;
    end else if (fire) begin
      rd_data <= nxt;
      lane_q  <= last ? 2'd0 : lane_q + 2'd1;
    end
  end
endmodule

// File: rtl/bm_unpacker_chk.sv
module bm_unpacker_chk #(
  parameter int BYTE_W = 9
) (
  input logic                clk,
  input logic                mrst_n,
  input logic                prst_n,
  input logic                rd_en,
  input logic                fifo_valid,
  input logic                fifo_pop,
  input logic [4*BYTE_W-1:0] rd_data,
  input logic [1:0]          mode,
  input logic [1:0]          lane
);
  localparam int LONG_W = 4 * BYTE_W;
  localparam int WORD_W = 2 * BYTE_W;

  // R6
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    fifo_pop |-> (rd_en && fifo_valid));

  // R6
  wide_pop_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == 2'd0 && rd_en && fifo_valid) |-> fifo_pop);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (!fifo_valid) |=> $stable(rd_data));

  // R8
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == 2'd2) |-> (rd_data[LONG_W-1:BYTE_W] == '0));

  // R8
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == 2'd1) |-> (rd_data[LONG_W-1:WORD_W] == '0));

  // R4
  mrst_clear_chk: assert property (@(posedge clk) disable iff (!prst_n)
    (!mrst_n) |=> (rd_data == '0 && lane == 2'd0));

  // R5
  prst_clear_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_n) |=> (rd_data == '0 && lane == 2'd0 && $stable(mode)));

  // R1
  word_lane_range_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == 2'd1) |-> (lane <= 2'd1));
endmodule

bind bm_unpacker bm_unpacker_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .rd_en(rd_en),
  .fifo_valid(fifo_valid), .fifo_pop(fifo_pop), .rd_data(rd_data),
  .mode(mode_q), .lane(lane_q)
);

// File: tb/sim_bm_unpacker.sv
`timescale 1ns/1ps
module sim_bm_unpacker;
  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_big = 1'b0;
  logic rd_en = 1'b0;
  logic fifo_pop;
  logic [35:0] rd_data;
  int idx = 0, nwords = 0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  function automatic logic [35:0] word_of(int i);
    logic [63:0] t;
    t = (64'(i) + 64'd1) * 64'h9E3779B97F4A7C15;
    return t[63:28];
  endfunction

  function automatic logic [35:0] slice(logic [35:0] w, int n, int k, bit big);
    int wd, s;
    logic [63:0] ww;
    wd = 36 / n;
    s = big ? (n - 1 - k) : k;
    ww = (64'(w) >> (s * wd)) & ((64'h1 << wd) - 64'h1);
    return ww[35:0];
  endfunction

  wire        fifo_valid = (idx < nwords);
  wire [35:0] fifo_data  = word_of(idx);

  always #2 clk = ~clk;

  bm_unpacker u0 (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte), .cfg_big(cfg_big),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic master_reset(bit nar, bit byt, bit big);
    @(negedge clk);
    mrst_n = 1'b0; cfg_narrow = nar; cfg_byte = byt; cfg_big = big;
    repeat (2) @(negedge clk);
    mrst_n = 1'b1;
    // R9: pins flipped after release must not matter
    cfg_narrow = ~nar; cfg_byte = ~byt; cfg_big = ~big;
    chk("R4 reset output", rd_data, 36'h0);
  endtask

  task automatic do_read(string tag, bit exp_pop, logic [35:0] exp);
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    chk({tag, " pop"}, {35'h0, fifo_pop}, {35'h0, exp_pop});
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    chk({tag, " data"}, rd_data, exp);
    if (fifo_pop === 1'b1 || exp_pop) idx = exp_pop ? idx + 1 : idx;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int big = 0; big < 2; big++) begin
      for (int m = 0; m < 3; m++) begin
        int n;
        logic [35:0] last_v;
        n = (m == 0) ? 1 : (m == 1) ? 2 : 4;
        idx = 0; nwords = 0;
        master_reset(m != 0, m == 2, big[0]);
        nwords = 4;
        // R1 R2 R3 R6 R8 R9: full sweep of lanes over several words
        for (int w = 0; w < 4; w++) begin
          for (int k = 0; k < n; k++) begin
            do_read(big ? "R2 R1 R9 lane" : "R3 R1 R9 lane", k == n - 1,
                    slice(word_of(w), n, k, big[0]));
          end
        end
        chk("R6 words consumed", 36'(idx), 36'd4);
        // R7: read on empty FIFO holds output, no pop, lane unchanged
        last_v = rd_data;
        do_read("R7 empty read", 1'b0, last_v);
        nwords = 5;
        do_read("R7 lane kept", n == 1, slice(word_of(4), n, 0, big[0]));
      end
    end

    // R5: partial reset in the middle of a word, byte mode big endian
    idx = 0; nwords = 0;
    master_reset(1'b1, 1'b1, 1'b1);
    nwords = 3;
    do_read("R5 pre lane0", 1'b0, slice(word_of(0), 4, 0, 1'b1));
    do_read("R5 pre lane1", 1'b0, slice(word_of(0), 4, 1, 1'b1));
    @(negedge clk); prst_n = 1'b0;
    @(negedge clk); prst_n = 1'b1;
    chk("R5 partial reset output", rd_data, 36'h0);
    for (int k = 0; k < 4; k++)
      do_read("R5 restart", k == 3, slice(word_of(0), 4, k, 1'b1));
    do_read("R5 config kept", 1'b0, slice(word_of(1), 4, 0, 1'b1));

    // R4: master reset mid-word returns to lane 0 and zero output
    master_reset(1'b1, 1'b0, 1'b0);
    do_read("R4 lane after reset", 1'b0, slice(word_of(idx), 2, 0, 1'b0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule